// File: doc/BRIEF.md
# Transmit Frame Packer

The packer turns a sequence of 32-bit processor writes to one data register into an outgoing Ethernet frame. It then hands that frame on as a byte stream with valid, last and ready.

The first write of a frame is a header word. Its low half holds the payload length, which counts neither the 14-byte MAC header nor the checksum. Its upper two bytes are the first two bytes of the frame. Every later write carries four more frame bytes. The packer works out how many bytes to expect, which depends on whether the checksum is appended downstream. It closes the frame once enough bytes have arrived. When padding is on, it fills short frames with zeros up to the 60-byte minimum.

A length that is too large is reported on an error pulse, and the packer then waits for an acknowledge. A completed frame is reported on an empty pulse. While the frame drains, the packer reports busy and takes no data writes.

Top module: `tx_frame_packer`

## Requirements
- R1: After reset the packer waits for a header word, with `busy`, `m_valid`, `evt_empty` and `evt_error` all low.
- R2: A header word whose length field, bits 15:0, is above 2032 starts no frame. It pulses `evt_error` in the cycle after the write, and no byte is streamed. A length of exactly 2032 is accepted.
- R3: The expected byte total is the length plus 14. If `ctl_hw_fcs` is low when the header word is written, 4 more bytes are expected.
- R4: Bits 23:16 and 31:24 of the header word are frame bytes 0 and 1. Each later write adds four bytes, bits 7:0 first and bits 31:24 last.
- R5: The frame closes on the write that brings the byte count to or past the expected total. The streamed length is the length field plus 14 in both checksum modes.
- R6: If `ctl_pad` is high on the closing write and the streamed length is under 60, the stream is 60 bytes long. Every byte at or beyond the length field plus 14 is zero, including bytes that were written there.
- R7: `evt_empty` is a single-cycle pulse in the cycle after the closing write. The stream starts in that same cycle.
- R8: A pulse on `err_ack` returns the packer to header-waiting, either after a length error or partway through a frame. Data writes made in the error state are ignored.
- R9: `busy` is high while a frame is streamed, and data writes during that time are ignored.
- R10: While `m_valid` is high and `m_ready` is low, the byte and `m_last` hold. `m_last` marks the final byte, after which the packer waits for a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe for the data register |
| wr_data | input | 32 | Data register write value |
| busy | output | 1 | Frame draining; data writes ignored |
| ctl_pad | input | 1 | Pad short frames to 60 bytes |
| ctl_hw_fcs | input | 1 | Checksum appended downstream (not written) |
| err_ack | input | 1 | Transmit error acknowledge strobe |
| m_valid | output | 1 | Stream byte valid |
| m_data | output | 8 | Stream byte |
| m_last | output | 1 | Final byte of frame |
| m_ready | input | 1 | Stream sink ready |
| evt_empty | output | 1 | Frame-complete pulse |
| evt_error | output | 1 | Length-error pulse |

## Verification
The bench compares the closing write in both checksum modes, where the totals differ by one word. A packer that ignores the mode would either close a word early or wait for a write that never comes. Padded frames whose last write spills past the real length check that the spilled bytes come out as zero and not as stale data. Lengths of 2032 and 2033 probe the limit, and the largest accepted frame in checksum-off mode writes past the buffer end, so a missing bounds guard would corrupt the frame. Writes made while draining, in the error state and before an abort must all leave the next frame intact, which would not hold if the state machine took them as headers.

// File: rtl/txfp_pkg.sv
package txfp_pkg;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_FILL = 2'd1,
        ST_SEND = 2'd2,
        ST_ERR  = 2'd3
    } txfp_state_e;

    localparam int unsigned DEF_BUF_BYTES = 2048;
    localparam int unsigned DEF_MAX_LEN   = 2032;
    localparam int unsigned MAC_HDR_BYTES = 14;
    localparam int unsigned FCS_BYTES     = 4;
    localparam int unsigned MIN_FRAME     = 60;

    // Bytes the writer will supply: header plus payload, plus checksum room
    // when the checksum is not generated downstream.
    function automatic int unsigned expected_total(input int unsigned len,
                                                   input logic hw_fcs);
        return len + MAC_HDR_BYTES + (hw_fcs ? 0 : FCS_BYTES);
    endfunction

endpackage

// File: rtl/txfp_buffer.sv
module txfp_buffer #(
    parameter int unsigned BUF_BYTES = txfp_pkg::DEF_BUF_BYTES,
    parameter int unsigned CW        = $clog2(BUF_BYTES) + 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [CW-1:0] wr_base,
    input  logic [3:0]    wr_lanes,
    input  logic [31:0]   wr_bytes,
    input  logic [CW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);
    localparam int unsigned AW = $clog2(BUF_BYTES);

    logic [7:0] mem [BUF_BYTES];

    always_ff @(posedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (we && wr_lanes[k] && ((wr_base + CW'(k)) < CW'(BUF_BYTES))) begin
                mem[AW'(wr_base + CW'(k))] <= wr_bytes[8*k +: 8];
            end
        end
    end

    assign rd_byte = mem[rd_idx[AW-1:0]];

endmodule

// File: rtl/txfp_ctrl.sv
module txfp_ctrl
    import txfp_pkg::*;
#(
    parameter int unsigned BUF_BYTES = DEF_BUF_BYTES,
    parameter int unsigned MAX_LEN   = DEF_MAX_LEN,
    parameter int unsigned CW        = $clog2(BUF_BYTES) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [31:0]   wr_data,
    input  logic          ctl_pad,
    input  logic          ctl_hw_fcs,
    input  logic          err_ack,
    input  logic          m_ready,
    input  logic [7:0]    rd_byte,
    output logic          busy,
    output logic          m_valid,
    output logic [7:0]    m_data,
    output logic          m_last,
    output logic          evt_empty,
    output logic          evt_error,
    output logic          buf_we,
    output logic [CW-1:0] buf_base,
    output logic [3:0]    buf_lanes,
    output logic [31:0]   buf_bytes,
    output logic [CW-1:0] rd_idx
);
    txfp_state_e   st;
    logic [CW-1:0] cnt, total, raw_len, emit_len;
    logic [15:0]   hdr_len;
    logic          too_long;
    logic [CW-1:0] cnt_next, padded_len;

    assign hdr_len    = wr_data[15:0];
    assign too_long   = hdr_len > 16'(MAX_LEN);
    assign cnt_next   = cnt + CW'(4);
    assign padded_len = (ctl_pad && raw_len < CW'(MIN_FRAME)) ? CW'(MIN_FRAME) : raw_len;

    // Buffer write lanes: a header word supplies two bytes at offset 0.
    assign buf_we    = wr_valid && ((st == ST_HDR && !too_long) || st == ST_FILL);
    assign buf_base  = (st == ST_HDR) ? '0 : cnt;
    assign buf_lanes = (st == ST_HDR) ? 4'b0011 : 4'b1111;
    assign buf_bytes = (st == ST_HDR) ? {16'h0000, wr_data[31:16]} : wr_data;

    assign busy    = (st == ST_SEND);
    assign m_valid = (st == ST_SEND);
    assign m_last  = m_valid && (rd_idx == emit_len - CW'(1));
    assign m_data  = (rd_idx < raw_len) ? rd_byte : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_HDR;
            cnt       <= '0;
            total     <= '0;
            raw_len   <= '0;
            emit_len  <= '0;
            rd_idx    <= '0;
            evt_empty <= 1'b0;
            evt_error <= 1'b0;
        end else begin
            evt_empty <= 1'b0;
            evt_error <= 1'b0;
            case (st)
                ST_HDR: begin
                    if (wr_valid) begin
                        if (too_long) begin
                            st        <= ST_ERR;
                            evt_error <= 1'b1;
                        end else begin
                            st      <= ST_FILL;
                            cnt     <= CW'(2);
                            total   <= CW'(expected_total(32'(hdr_len), ctl_hw_fcs));
                            raw_len <= CW'(hdr_len) + CW'(MAC_HDR_BYTES);
                        end
                    end
                end
                ST_FILL: begin
                    if (err_ack) begin
                        st <= ST_HDR;
                    end else if (wr_valid) begin
                        cnt <= cnt_next;
                        if (cnt_next >= total) begin
                            st        <= ST_SEND;
                            emit_len  <= padded_len;
                            rd_idx    <= '0;
                            evt_empty <= 1'b1;
                        end
                    end
                end
                ST_SEND: begin
                    if (m_ready) begin
                        if (m_last) st <= ST_HDR;
                        else        rd_idx <= rd_idx + CW'(1);
                    end
                end
                default: begin
                    if (err_ack) st <= ST_HDR;
                end
            endcase
        end
    end

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last)); // R10
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        m_valid && m_ready && m_last |=> !m_valid); // R10
    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(evt_empty && evt_error)); // R7
    AST_EMPTY_STARTS: assert property (@(posedge clk) disable iff (rst)
        evt_empty |-> m_valid && rd_idx == '0); // R7
    AST_ERR_NO_STREAM: assert property (@(posedge clk) disable iff (rst)
        evt_error |-> !m_valid); // R2

endmodule

// File: rtl/tx_frame_packer.sv
module tx_frame_packer #(
    parameter int unsigned BUF_BYTES = txfp_pkg::DEF_BUF_BYTES,
    parameter int unsigned MAX_LEN   = txfp_pkg::DEF_MAX_LEN
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    output logic        busy,
    input  logic        ctl_pad,
    input  logic        ctl_hw_fcs,
    input  logic        err_ack,
    output logic        m_valid,
    output logic [7:0]  m_data,
    output logic        m_last,
    input  logic        m_ready,
    output logic        evt_empty,
    output logic        evt_error
);
    localparam int unsigned CW = $clog2(BUF_BYTES) + 1;

    logic          buf_we;
    logic [CW-1:0] buf_base, rd_idx;
    logic [3:0]    buf_lanes;
    logic [31:0]   buf_bytes;
    logic [7:0]    rd_byte;

    txfp_ctrl #(.BUF_BYTES(BUF_BYTES), .MAX_LEN(MAX_LEN), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .ctl_pad(ctl_pad), .ctl_hw_fcs(ctl_hw_fcs), .err_ack(err_ack),
        .m_ready(m_ready), .rd_byte(rd_byte), .busy(busy),
        .m_valid(m_valid), .m_data(m_data), .m_last(m_last),
        .evt_empty(evt_empty), .evt_error(evt_error),
        .buf_we(buf_we), .buf_base(buf_base), .buf_lanes(buf_lanes),
        .buf_bytes(buf_bytes), .rd_idx(rd_idx)
    );

    txfp_buffer #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_buf (
        .clk(clk), .we(buf_we), .wr_base(buf_base), .wr_lanes(buf_lanes),
        .wr_bytes(buf_bytes), .rd_idx(rd_idx), .rd_byte(rd_byte)
    );

    AST_BUSY_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        busy |-> !buf_we); // R9
    AST_BUSY_IS_STREAM: assert property (@(posedge clk) disable iff (rst)
        busy == m_valid); // R9

endmodule

// File: tb/tx_frame_packer_tb.sv
module tx_frame_packer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ctl_pad = 1'b0;
    logic        ctl_hw_fcs = 1'b1;
    logic        err_ack = 1'b0;
    logic        m_ready = 1'b1;
    logic        busy, m_valid, m_last, evt_empty, evt_error;
    logic [7:0]  m_data;

    int checks = 0;
    int failures = 0;
    logic [7:0] got [2100];

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_frame_packer u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .busy(busy), .ctl_pad(ctl_pad), .ctl_hw_fcs(ctl_hw_fcs),
        .err_ack(err_ack), .m_valid(m_valid), .m_data(m_data),
        .m_last(m_last), .m_ready(m_ready), .evt_empty(evt_empty),
        .evt_error(evt_error)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(input int seed, input int i);
        return 8'((i * 13) + (seed * 5) + 1);
    endfunction

    task automatic write_word(input logic [31:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        err_ack = 1'b1;
        @(negedge clk);
        err_ack = 1'b0;
    endtask

    task automatic collect(input bit stall, output int n);
        int cyc = 0;
        n = 0;
        forever begin
            m_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            cyc++;
            #1;
            if (m_valid && m_ready) begin
                got[n] = m_data;
                n++;
                if (m_last) begin
                    @(negedge clk);
                    break;
                end
            end
            if (cyc > 8000) break;
            @(negedge clk);
        end
        m_ready = 1'b1;
    endtask

    // Writes one whole frame, drains it and checks everything about it.
    task automatic run_frame(input string name, input int len, input bit hw_fcs,
                             input bit pad, input bit stall, input int seed);
        int total, nw, exp_len, n, bad, early;
        ctl_hw_fcs = hw_fcs;
        ctl_pad    = pad;
        total = len + 14 + (hw_fcs ? 0 : 4);
        nw = 0;
        while (2 + 4 * nw < total) nw++;
        exp_len = len + 14;
        if (pad && exp_len < 60) exp_len = 60;
        write_word({fb(seed, 1), fb(seed, 0), 16'(len)});
        chk(!evt_error && !m_valid, "R2", {name, " header accepted"}, int'(evt_error), 0);
        early = 0;
        for (int k = 0; k < nw; k++) begin
            write_word({fb(seed, 2+4*k+3), fb(seed, 2+4*k+2), fb(seed, 2+4*k+1), fb(seed, 2+4*k)});
            if (k < nw - 1 && (evt_empty || m_valid)) early++;
        end
        chk(early == 0, "R3", {name, " no close before expected total"}, early, 0);
        chk(evt_empty && m_valid && busy, "R7", {name, " empty pulse with stream start"}, int'(evt_empty), 1);
        collect(stall, n);
        chk(n == exp_len, "R5", {name, " streamed length"}, n, exp_len);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (got[i] !== ((i < len + 14) ? fb(seed, i) : 8'h00)) bad++;
        end
        chk(bad == 0, (pad && len + 14 < 60) ? "R6" : "R4", {name, " byte mismatches"}, bad, 0);
        chk(!m_valid && !busy && !evt_empty, "R10", {name, " idle after last"}, int'(m_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic t_reset();
        chk(!busy && !m_valid && !evt_empty && !evt_error, "R1", "reset state",
            int'({busy, m_valid, evt_empty, evt_error}), 0);
    endtask

    task automatic t_oversize();
        int seen = 0;
        ctl_hw_fcs = 1'b1;
        write_word({16'hABCD, 16'd2033});
        chk(evt_error && !m_valid, "R2", "length 2033 flags error", int'(evt_error), 1);
        @(negedge clk);
        chk(!evt_error, "R2", "error is a single pulse", int'(evt_error), 0);
        for (int k = 0; k < 20; k++) begin
            write_word(32'h0000_0010 + k);
            if (evt_empty || m_valid || evt_error) seen++;
        end
        chk(seen == 0, "R8", "writes ignored in error state", seen, 0);
        pulse_ack();
        run_frame("after_ack", 30, 1'b1, 1'b0, 1'b0, 7);
    endtask

    task automatic t_abort();
        ctl_hw_fcs = 1'b1;
        write_word({8'h11, 8'h22, 16'd40});
        write_word(32'hFFFF_FFFF);
        write_word(32'hEEEE_EEEE);
        pulse_ack();
        chk(!m_valid && !busy, "R8", "abort mid-frame leaves idle", int'(m_valid), 0);
        run_frame("after_abort", 20, 1'b1, 1'b0, 1'b0, 9);
    endtask

    task automatic t_busy();
        int n, bad;
        ctl_hw_fcs = 1'b1;
        ctl_pad    = 1'b0;
        write_word({fb(3, 1), fb(3, 0), 16'd10});
        for (int k = 0; k < 6; k++)
            write_word({fb(3, 2+4*k+3), fb(3, 2+4*k+2), fb(3, 2+4*k+1), fb(3, 2+4*k)});
        m_ready = 1'b0;
        @(negedge clk);
        chk(busy && m_valid, "R9", "busy while draining", int'(busy), 1);
        write_word(32'h5555_0005);
        write_word(32'h6666_6666);
        chk(busy && !evt_empty && !evt_error, "R9", "writes ignored while busy", int'(evt_empty), 0);
        collect(1'b0, n);
        bad = 0;
        for (int i = 0; i < n; i++) if (got[i] !== fb(3, i)) bad++;
        chk(n == 24 && bad == 0, "R9", "frame intact despite busy writes", n, 24);
        chk(!m_valid && !busy, "R9", "no frame from busy writes", int'(m_valid), 0);
        run_frame("after_busy", 50, 1'b1, 1'b0, 1'b0, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_frame("fcs_hw_50", 50, 1'b1, 1'b0, 1'b0, 1);     // R3 R5 R7: 16 data writes
        run_frame("fcs_sw_50", 50, 1'b0, 1'b0, 1'b0, 2);     // R3 R5: 17 data writes, 64 bytes out
        run_frame("pad_10", 10, 1'b1, 1'b1, 1'b0, 3);        // R6: spill bytes 24,25 must be zero
        run_frame("pad_sw_3", 3, 1'b0, 1'b1, 1'b1, 5);       // R6 R10 with stalls
        run_frame("nopad_10", 10, 1'b1, 1'b0, 1'b0, 6);      // R6 off: 24 bytes
        run_frame("pad_long_60", 46, 1'b1, 1'b1, 1'b0, 8);   // R6 no pad at exactly 60
        run_frame("stall_77", 77, 1'b0, 1'b0, 1'b1, 10);     // R10 back-pressure
        run_frame("max_2032", 2032, 1'b0, 1'b0, 1'b0, 11);   // R2 limit accepted
        t_oversize();
        t_abort();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule